// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block times the conversion cycle of a successive-approximation analog-to-digital converter. A conversion opens with a sampling window. During that window `sample_en` is high. After the window the block runs a binary search. Each step drives a trial code on `dac_code`, reads the external comparator on `cmp_in`, and keeps or clears the trial bit. The search goes from the most significant bit down to the bit that the selected resolution requires. When the last bit is settled, the block registers the result and raises `done` for one cycle. `done_grp` carries the channel group that owns the result.

Every step is counted in converter clocks. A converter clock is one tick of an internal divider that runs from `clk` by 1, 2, 4 or 8. The sampling window length comes from a 2-bit code, and that code has a different meaning in long mode than in short mode.

There is a set of channel-group registers, and each one holds a channel number. In software-trigger mode, a write to group 0 starts a conversion. In hardware-trigger mode, each trigger pulse starts the next group in round-robin order. A write to the group that is converting aborts that conversion. In continuous mode, the block restarts the same group after each result.

Top module: `sar_seq`

## Requirements
- R1: While reset is held, and after it is released, `active`, `done`, `sample_en` and `result` are all 0.
- R2: In short mode (`long_mode`=0), `period_code` values 0, 1, 2 and 3 give a sampling window of 2, 4, 6 and 8 converter clocks. `sample_en` is high for exactly that window times the divide length, counted in `clk` cycles.
- R3: In long mode (`long_mode`=1), the same `period_code` values give windows of 12, 16, 20 and 24 converter clocks.
- R4: `div_sel` values 0, 1, 2 and 3 give a converter clock of `clk` divided by 1, 2, 4 and 8. Take D as the divide length, N as the window and W as the number of result bits. From the start edge, `done` rises exactly (N+W)*D `clk` cycles later.
- R5: `res_sel` values 0, 1 and 2 select 8, 10 and 12 result bits. The reserved value 3 behaves as 12 bits. `bit_strobe` pulses exactly W times in one conversion.
- R6: The search runs from bit 11 downward. The comparator reports 1 when the input is at or above `dac_code`. `result` is the input truncated to W bits, left-aligned in 12 bits, with the lower 12-W bits set to 0.
- R7: `active` is high from the cycle after the start edge until the cycle that shows `done`. It is low in that cycle unless continuous mode restarts the conversion.
- R8: `done` lasts one cycle. `done_grp` gives the index of the group that converted. `result` changes only in a cycle where `done` is high.
- R9: In software-trigger mode (`hw_mode`=0), a write to group 0 starts a conversion. Writes to groups 1 and above never start one, and `hw_trig` is ignored.
- R10: In hardware-trigger mode, a `hw_trig` pulse while idle starts groups 0, 1, ..., NGRP-1 and then 0 again, in turn. A `hw_trig` pulse while busy is ignored and does not advance the turn. Group writes do not start a conversion.
- R11: A write to the converting group aborts the conversion. `active` is low in the next cycle and no `done` follows. In software-trigger mode a write to group 0 during its own conversion restarts the full sequence. A write to any other group leaves the running conversion untouched.
- R12: With `cont_en` high at the final bit, a new conversion of the same group starts at the edge that produces `done`, with the same latency.
- R13: While a conversion runs, `conv_chan` shows the channel number stored in the converting group's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Converter clock divide select (1, 2, 4, 8) |
| long_mode | input | 1 | 1 selects long sampling windows |
| period_code | input | 2 | Sampling window code |
| res_sel | input | 2 | Result width select |
| cont_en | input | 1 | Continuous conversion enable |
| hw_mode | input | 1 | 1 selects hardware-trigger mode |
| hw_trig | input | 1 | Hardware trigger pulse |
| grp_wr | input | 1 | Channel-group register write strobe |
| grp_wr_idx | input | GIW | Group index written |
| grp_wr_chan | input | CHW | Channel number written |
| cmp_in | input | 1 | Comparator output, 1 when input >= dac_code |
| sample_en | output | 1 | Sampling window active |
| bit_strobe | output | 1 | One-cycle pulse when a bit is decided |
| dac_code | output | 12 | Current trial code |
| result | output | 12 | Left-aligned conversion result |
| done | output | 1 | One-cycle result pulse |
| done_grp | output | GIW | Group that produced the result |
| active | output | 1 | Conversion in progress |
| conv_chan | output | CHW | Channel of the converting group |

## Verification
The assertions rely on two input conditions. First, the comparator settles within the cycle that follows a change of `dac_code`. Second, the timing selects (`div_sel`, `long_mode`, `period_code`, `res_sel`) stay still while a conversion runs. The bench models the comparator combinationally from a held analog value, so the first condition holds. It changes the timing selects only between conversions, so the second holds too. The bench drives trigger and write strobes for exactly one cycle, on the falling edge, so every start edge is known. It changes `cont_en` only away from the final bit of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_MAX   = 12;
    localparam int WIN_W     = 5;
    localparam int BPOS_W    = 4;
    localparam int DIV_SEL_W = 2;
    localparam int CNT_W     = (1 << DIV_SEL_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic [WIN_W-1:0]     win;
        logic [BPOS_W-1:0]    lsb_pos;
        logic [DIV_SEL_W-1:0] div_sel;
    } conv_cfg_t;

    function automatic logic [WIN_W-1:0] window_len(input logic long_m, input logic [1:0] code);
        if (long_m)
            return 5'd12 + {1'b0, code, 2'b00};
        else
            return 5'd2 + {2'b00, code, 1'b0};
    endfunction

    function automatic logic [BPOS_W-1:0] lsb_of(input logic [1:0] res);
        case (res)
            2'd0:    return 4'd4;
            2'd1:    return 4'd2;
            default: return 4'd0;
        endcase
    endfunction

    function automatic conv_cfg_t make_cfg(input logic long_m, input logic [1:0] code,
                                           input logic [1:0] res, input logic [DIV_SEL_W-1:0] dsel);
        conv_cfg_t c;
        c.win     = window_len(long_m, code);
        c.lsb_pos = lsb_of(res);
        c.div_sel = dsel;
        return c;
    endfunction

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv
    import sar_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb lim = CNT_W'((1 << div_sel) - 1);

    assign tick = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0 && !restart) |=> !tick)
        else $error("converter ticks closer than the divide length");

endmodule

// File: rtl/sar_grp_regs.sv
module sar_grp_regs #(
    parameter int NGRP = 4,
    parameter int CHW  = 5,
    parameter int GIW  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [GIW-1:0] wr_idx,
    input  logic [CHW-1:0] wr_chan,
    input  logic           adv,
    input  logic [GIW-1:0] rd_idx,
    output logic [CHW-1:0] rd_chan,
    output logic [GIW-1:0] turn
);

    logic [CHW-1:0] chan_q [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                chan_q[g] <= '0;
            else if (wr && wr_idx == GIW'(g))
                chan_q[g] <= wr_chan;
        end
    end

    always_comb begin
        rd_chan = '0;
        for (int g = 0; g < NGRP; g++)
            if (rd_idx == GIW'(g)) rd_chan = chan_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            turn <= '0;
        else if (adv)
            turn <= (turn == GIW'(NGRP - 1)) ? '0 : turn + 1'b1;
    end

    // R10
    turn_range_chk: assert property (@(posedge clk) disable iff (rst)
        turn <= GIW'(NGRP - 1))
        else $error("group turn pointer out of range");

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_seq_pkg::*;
#(
    parameter int GIW = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [GIW-1:0]     start_grp,
    input  logic               abort,
    input  conv_cfg_t          cfg_in,
    input  logic               cmp_in,
    input  logic               cont_en,
    output logic               sample_en,
    output logic               bit_strobe,
    output logic [RES_MAX-1:0] dac_code,
    output logic [RES_MAX-1:0] result,
    output logic               done,
    output logic [GIW-1:0]     done_grp,
    output logic [GIW-1:0]     cur_grp,
    output logic               active
);

    sar_state_e         state_q;
    conv_cfg_t          cfg_q;
    logic [WIN_W-1:0]   tcnt_q;
    logic [BPOS_W-1:0]  bpos_q;
    logic [RES_MAX-1:0] trial_q;
    logic [RES_MAX-1:0] trial_nx;
    logic               tick;
    logic               last_bit;
    logic               auto_rs;
    logic               div_restart;

    assign last_bit    = (bpos_q == cfg_q.lsb_pos);
    assign auto_rs     = (state_q == ST_CONV) && tick && last_bit && cont_en && !abort && !start;
    assign div_restart = start || auto_rs;

    sar_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (div_restart),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    always_comb begin
        trial_nx = trial_q;
        if (!cmp_in)
            trial_nx[bpos_q] = 1'b0;
        if (!last_bit)
            trial_nx[bpos_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            tcnt_q   <= '0;
            bpos_q   <= '0;
            trial_q  <= '0;
            result   <= '0;
            done     <= 1'b0;
            done_grp <= '0;
            cur_grp  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state_q <= ST_SAMPLE;
                cfg_q   <= cfg_in;
                tcnt_q  <= '0;
                trial_q <= '0;
                cur_grp <= start_grp;
            end else if (abort) begin
                state_q <= ST_IDLE;
                trial_q <= '0;
            end else begin
                case (state_q)
                    ST_SAMPLE: begin
                        if (tick) begin
                            if (tcnt_q == cfg_q.win - 1'b1) begin
                                state_q <= ST_CONV;
                                bpos_q  <= BPOS_W'(RES_MAX - 1);
                                trial_q <= RES_MAX'(1) << (RES_MAX - 1);
                            end else begin
                                tcnt_q <= tcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_CONV: begin
                        if (tick) begin
                            if (last_bit) begin
                                result   <= trial_nx;
                                done     <= 1'b1;
                                done_grp <= cur_grp;
                                trial_q  <= '0;
                                if (cont_en) begin
                                    state_q <= ST_SAMPLE;
                                    cfg_q   <= cfg_in;
                                    tcnt_q  <= '0;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else begin
                                trial_q <= trial_nx;
                                bpos_q  <= bpos_q - 1'b1;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sample_en  = (state_q == ST_SAMPLE);
    assign bit_strobe = (state_q == ST_CONV) && tick;
    assign dac_code   = trial_q;
    assign active     = (state_q != ST_IDLE);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held longer than one cycle");

    // R7
    done_after_active_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active))
        else $error("done without a running conversion");

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result))
        else $error("result changed outside a done cycle");

    // R6
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV) |-> (bpos_q >= cfg_q.lsb_pos))
        else $error("approximation ran below the selected width");

    // R2
    window_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMPLE) |-> (tcnt_q < cfg_q.win))
        else $error("sampling window count overran");

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter  int NGRP = 4,
    parameter  int CHW  = 5,
    localparam int GIW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         div_sel,
    input  logic               long_mode,
    input  logic [1:0]         period_code,
    input  logic [1:0]         res_sel,
    input  logic               cont_en,
    input  logic               hw_mode,
    input  logic               hw_trig,
    input  logic               grp_wr,
    input  logic [GIW-1:0]     grp_wr_idx,
    input  logic [CHW-1:0]     grp_wr_chan,
    input  logic               cmp_in,
    output logic               sample_en,
    output logic               bit_strobe,
    output logic [RES_MAX-1:0] dac_code,
    output logic [RES_MAX-1:0] result,
    output logic               done,
    output logic [GIW-1:0]     done_grp,
    output logic               active,
    output logic [CHW-1:0]     conv_chan
);

    logic           hits_cur;
    logic           sw_start;
    logic           hw_start;
    logic           start;
    logic           abort;
    logic [GIW-1:0] start_grp;
    logic [GIW-1:0] cur_grp;
    logic [GIW-1:0] turn;
    conv_cfg_t      cfg_now;

    assign cfg_now   = make_cfg(long_mode, period_code, res_sel, div_sel);
    assign hits_cur  = grp_wr && active && (grp_wr_idx == cur_grp);
    assign sw_start  = grp_wr && !hw_mode && (grp_wr_idx == '0) && (!active || hits_cur);
    assign hw_start  = hw_mode && hw_trig && !active;
    assign start     = sw_start || hw_start;
    assign abort     = hits_cur;
    assign start_grp = sw_start ? '0 : turn;

    sar_grp_regs #(.NGRP(NGRP), .CHW(CHW), .GIW(GIW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (grp_wr),
        .wr_idx  (grp_wr_idx),
        .wr_chan (grp_wr_chan),
        .adv     (hw_start),
        .rd_idx  (cur_grp),
        .rd_chan (conv_chan),
        .turn    (turn)
    );

    sar_core #(.GIW(GIW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_grp  (start_grp),
        .abort      (abort),
        .cfg_in     (cfg_now),
        .cmp_in     (cmp_in),
        .cont_en    (cont_en),
        .sample_en  (sample_en),
        .bit_strobe (bit_strobe),
        .dac_code   (dac_code),
        .result     (result),
        .done       (done),
        .done_grp   (done_grp),
        .cur_grp    (cur_grp),
        .active     (active)
    );

    // R9
    sw_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!hw_mode && !active && (!grp_wr || grp_wr_idx != '0)) |=> !active)
        else $error("conversion started without a group 0 write");

    // R10
    hw_start_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && hw_trig && !active) |=> (active && sample_en))
        else $error("hardware trigger did not start a conversion");

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && grp_wr && active && grp_wr_idx == cur_grp) |=> (!active && !done))
        else $error("write to the converting group did not abort");

endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NGRP = 4;
    localparam int CHW  = 5;
    localparam int GIW  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       div_sel = '0;
    logic             long_mode = 1'b0;
    logic [1:0]       period_code = '0;
    logic [1:0]       res_sel = 2'd2;
    logic             cont_en = 1'b0;
    logic             hw_mode = 1'b0;
    logic             hw_trig = 1'b0;
    logic             grp_wr = 1'b0;
    logic [GIW-1:0]   grp_wr_idx = '0;
    logic [CHW-1:0]   grp_wr_chan = '0;
    logic             cmp_in;
    logic             sample_en;
    logic             bit_strobe;
    logic [11:0]      dac_code;
    logic [11:0]      result;
    logic             done;
    logic [GIW-1:0]   done_grp;
    logic             active;
    logic [CHW-1:0]   conv_chan;
    logic [11:0]      v_in = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (dac_code <= v_in);

    sar_seq #(.NGRP(NGRP), .CHW(CHW)) u_sar_seq (
        .clk (clk), .rst (rst), .div_sel (div_sel), .long_mode (long_mode),
        .period_code (period_code), .res_sel (res_sel), .cont_en (cont_en),
        .hw_mode (hw_mode), .hw_trig (hw_trig), .grp_wr (grp_wr),
        .grp_wr_idx (grp_wr_idx), .grp_wr_chan (grp_wr_chan), .cmp_in (cmp_in),
        .sample_en (sample_en), .bit_strobe (bit_strobe), .dac_code (dac_code),
        .result (result), .done (done), .done_grp (done_grp), .active (active),
        .conv_chan (conv_chan)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic grp_write(input int idx, input int chan);
        @(negedge clk);
        grp_wr = 1'b1;
        grp_wr_idx = GIW'(idx);
        grp_wr_chan = CHW'(chan);
        @(posedge clk);
        #1;
        grp_wr = 1'b0;
    endtask

    task automatic hw_pulse();
        @(negedge clk);
        hw_trig = 1'b1;
        @(posedge clk);
        #1;
        hw_trig = 1'b0;
    endtask

    // Called at 1 time unit after the start edge; returns in the cycle showing done.
    task automatic measure(output int cyc, output int ns, output int nst, output int na);
        cyc = 0; ns = 0; nst = 0; na = 0;
        while (1) begin
            if (cyc > 0 && done) break;
            if (cyc > 4000) break;
            if (sample_en) ns++;
            if (bit_strobe) nst++;
            if (active) na++;
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic conv_check(input string req, input int nwin, input int nbits,
                              input int dlen, input int grp);
        int cyc, ns, nst, na;
        logic [11:0] exp_res;
        exp_res = v_in & (12'hFFF << (12 - nbits));
        measure(cyc, ns, nst, na);
        chk(cyc == (nwin + nbits) * dlen, req, "latency", cyc, (nwin + nbits) * dlen);
        chk(ns == nwin * dlen, req, "sample cycles", ns, nwin * dlen);
        chk(nst == nbits, req, "bit strobes", nst, nbits);
        chk(result == exp_res, req, "result", result, exp_res);
        chk(done_grp == GIW'(grp), req, "done group", done_grp, grp);
        chk(na == cyc, "R7", "active cycles", na, cyc);
        chk(!active, "R7", "active at done", active, 0);
        @(posedge clk);
        #1;
        chk(!done, "R8", "done width", done, 0);
    endtask

    task automatic t_reset();
        wait_cycles(3);
        chk(!active && !done && !sample_en && result == 0, "R1", "state in reset",
            {active, done, sample_en}, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_cycles(2);
        chk(!active && !done && result == 0, "R1", "state after reset", {active, done}, 0);
    endtask

    task automatic t_short();
        hw_mode = 0; long_mode = 0; div_sel = 0; res_sel = 2; v_in = 12'hA5C;
        for (int c = 0; c < 4; c++) begin
            period_code = 2'(c);
            grp_write(0, 1);
            conv_check("R2", 2 + 2 * c, 12, 1, 0);
        end
    endtask

    task automatic t_long();
        long_mode = 1; res_sel = 0; v_in = 12'h3C7;
        for (int c = 0; c < 4; c++) begin
            period_code = 2'(c);
            grp_write(0, 1);
            conv_check("R3", 12 + 4 * c, 8, 1, 0);
        end
        long_mode = 0;
    endtask

    task automatic t_div();
        period_code = 1; res_sel = 1; v_in = 12'h8F1;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            grp_write(0, 1);
            conv_check("R4", 4, 10, 1 << d, 0);
        end
        div_sel = 0;
    endtask

    task automatic t_res();
        logic [11:0] vals [4];
        vals[0] = 12'hFFF; vals[1] = 12'h000; vals[2] = 12'h7FF; vals[3] = 12'h801;
        period_code = 0;
        for (int r = 0; r < 4; r++) begin
            res_sel = 2'(r);
            for (int k = 0; k < 4; k++) begin
                v_in = vals[k];
                grp_write(0, 1);
                conv_check("R5/R6", 2, (r == 3) ? 12 : 8 + 2 * r, 1, 0);
            end
        end
        res_sel = 2;
        v_in = 12'h555;
        grp_write(0, 1);
        conv_check("R6", 2, 12, 1, 0);
    endtask

    task automatic t_sw_rules();
        int na;
        hw_mode = 0;
        for (int g = 1; g < NGRP; g++) begin
            grp_write(g, 9);
            na = 0;
            for (int i = 0; i < 40; i++) begin
                if (active) na++;
                wait_cycles(1);
            end
            chk(na == 0, "R9", "group write start", na, 0);
        end
        hw_pulse();
        na = 0;
        for (int i = 0; i < 40; i++) begin
            if (active) na++;
            wait_cycles(1);
        end
        chk(na == 0, "R9", "hw trigger in sw mode", na, 0);
    endtask

    task automatic t_turns();
        hw_mode = 1; res_sel = 0; period_code = 0; div_sel = 0; v_in = 12'h6A3;
        for (int g = 0; g < NGRP; g++) grp_write(g, 3 + 5 * g);
        wait_cycles(3);
        chk(!active, "R10", "group write in hw mode", active, 0);
        for (int k = 0; k < 5; k++) begin
            hw_pulse();
            chk(conv_chan == CHW'(3 + 5 * (k % NGRP)), "R13", "conv channel",
                conv_chan, 3 + 5 * (k % NGRP));
            conv_check("R10", 2, 8, 1, k % NGRP);
        end
        hw_pulse();
        fork
            conv_check("R10", 2, 8, 1, 1);
            begin
                repeat (6) @(negedge clk);
                hw_trig = 1'b1;
                @(negedge clk);
                hw_trig = 1'b0;
            end
        join
        hw_pulse();
        conv_check("R10", 2, 8, 1, 2);
    endtask

    task automatic t_abort();
        int nd;
        hw_mode = 1;
        hw_pulse();
        wait_cycles(4);
        grp_write(3, 7);
        chk(!active, "R11", "active after abort", active, 0);
        nd = 0;
        for (int i = 0; i < 60; i++) begin
            if (done) nd++;
            wait_cycles(1);
        end
        chk(nd == 0, "R11", "done after abort", nd, 0);
        hw_pulse();
        fork
            conv_check("R11", 2, 8, 1, 0);
            begin
                repeat (3) @(negedge clk);
                grp_wr = 1'b1;
                grp_wr_idx = 2'd2;
                @(negedge clk);
                grp_wr = 1'b0;
            end
        join
        hw_mode = 0;
        res_sel = 2;
        grp_write(0, 4);
        wait_cycles(5);
        grp_write(0, 4);
        conv_check("R11", 2, 12, 1, 0);
    endtask

    task automatic t_cont();
        int cyc, ns, nst, na;
        hw_mode = 0; cont_en = 1; period_code = 1; res_sel = 1; div_sel = 1; v_in = 12'hC3A;
        grp_write(0, 2);
        measure(cyc, ns, nst, na);
        chk(cyc == 28, "R12", "first latency", cyc, 28);
        chk(active, "R12", "restarted at done", active, 1);
        cont_en = 0;
        measure(cyc, ns, nst, na);
        chk(cyc == 28, "R12", "second latency", cyc, 28);
        chk(result == (v_in & 12'hFFC), "R12", "second result", result, v_in & 12'hFFC);
        chk(!active, "R12", "stopped after disable", active, 0);
        div_sel = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_short();
        t_long();
        t_div();
        t_res();
        t_sw_rules();
        t_turns();
        t_abort();
        t_cont();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule